// File: doc/BRIEF.md
# Code-Region Memory Privilege Controller

This block gates data accesses to two protected memory areas, a system area and a loader area, using four privilege bits. Each area has one bit that allows reads and one that allows writes. The block sorts the current instruction pointer into one of four code regions: boot ROM, system, loader or other. It sorts each data address the same way. A denied access raises a one-cycle fault pulse and a blocking output in the same cycle, so the memory skips the operation.

The privilege bits fall back to zero on their own once execution leaves trusted code. Register writes are filtered bit by bit according to the region the instruction pointer is in. A second register holds an AND mask. Software can load the mask and then issue a commit write. The commit write loads the privilege bits with the written value ANDed with the mask, and it clears the mask.

Top module: `mem_priv_ctrl`

## Requirements
- R1: After reset the privilege register reads 0x0F and the mask register reads 0x00.
- R2: Register reads use reg_sel_i. A value of 0 returns the privilege register, 1 returns the mask register, and 2 or 3 return 0. Bits 7..4 always read as 0.
- R3: A valid access to the system area is blocked when its enable bit is 0. Reads depend on privilege bit 2 and writes on bit 3. When an access is blocked, fault_o and acc_block_o are both 1 in that same cycle.
- R4: A valid access to the loader area is blocked in the same way when its enable bit is 0. Reads depend on bit 0 and writes on bit 1.
- R5: In any cycle where the instruction pointer is outside both boot ROM and system code, bits 3..2 of the privilege and mask registers become 0 at the next clock edge.
- R6: In any cycle where the instruction pointer is outside boot ROM, system code and loader code, bits 1..0 of both registers become 0 at the next clock edge.
- R7: Bits 3..2 may be written only from boot ROM or system code. Bits 1..0 may be written from boot ROM, system code or loader code. A write from any other region leaves those bits unchanged and raises no fault.
- R8: A write to the mask register (reg_sel_i = 1) follows the same per-bit permissions as R7.
- R9: A write to the privilege register (reg_sel_i = 0) clears the mask register.
- R10: A commit write (reg_sel_i = 2) loads each writable privilege bit with the written bit ANDed with the mask bit, and it clears the mask register.
- R11: Region bounds are inclusive and decoded with the priority boot ROM, then system, then loader. Accesses to boot ROM or to other addresses are never blocked.
- R12: fault_o and acc_block_o stay 0 whenever acc_valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ip_i | input | ADDR_W | Current instruction pointer |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 privilege, 1 mask, 2 commit |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| acc_valid_i | input | 1 | Data access request |
| acc_addr_i | input | ADDR_W | Data access address |
| acc_write_i | input | 1 | 1 for a write access, 0 for a read access |
| acc_block_o | output | 1 | Access must not be performed |
| fault_o | output | 1 | Protection fault pulse |

## Verification
The hardest state to reach is a commit whose result differs from a plain write. The mask must be loaded with a partial pattern, and the commit must follow it from trusted code. No privilege write may come in between, and the instruction pointer must not leave trusted code, because either of those would wipe the mask. Random stimulus keeps the instruction pointer in trusted regions most of the time, so this pattern shows up by chance. Directed sequences also build it on purpose from system code and from loader code. At the loader-code step, bits 3..2 are already being cleared, so the result depends only on the permission of bits 1..0.

// File: rtl/mem_priv_pkg.sv
package mem_priv_pkg;
  typedef enum logic [1:0] {
    RG_ROM   = 2'd0,
    RG_SYS   = 2'd1,
    RG_LDR   = 2'd2,
    RG_OTHER = 2'd3
  } region_e;

  localparam int unsigned PRIV_W  = 4;
  localparam int unsigned DATA_W  = 8;
  localparam logic [1:0] SEL_PRIV   = 2'd0;
  localparam logic [1:0] SEL_MASK   = 2'd1;
  localparam logic [1:0] SEL_COMMIT = 2'd2;

  // bit index of each enable
  localparam int unsigned B_LDR_RD = 0;
  localparam int unsigned B_LDR_WR = 1;
  localparam int unsigned B_SYS_RD = 2;
  localparam int unsigned B_SYS_WR = 3;
endpackage

// File: rtl/code_region_decode.sv
module code_region_decode
  import mem_priv_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ROM_LO = 'h0000,
  parameter logic [ADDR_W-1:0] ROM_HI = 'h0FFF,
  parameter logic [ADDR_W-1:0] SYS_LO = 'h1000,
  parameter logic [ADDR_W-1:0] SYS_HI = 'h1FFF,
  parameter logic [ADDR_W-1:0] LDR_LO = 'h2000,
  parameter logic [ADDR_W-1:0] LDR_HI = 'h2FFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);
  logic in_rom, in_sys, in_ldr;

  assign in_rom = (addr_i >= ROM_LO) && (addr_i <= ROM_HI);
  assign in_sys = (addr_i >= SYS_LO) && (addr_i <= SYS_HI);
  assign in_ldr = (addr_i >= LDR_LO) && (addr_i <= LDR_HI);

  always_comb begin
    if (in_rom)      region_o = RG_ROM;
    else if (in_sys) region_o = RG_SYS;
    else if (in_ldr) region_o = RG_LDR;
    else             region_o = RG_OTHER;
  end
endmodule

// File: rtl/priv_reg_file.sv
module priv_reg_file
  import mem_priv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  region_e           ip_region_i,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [PRIV_W-1:0] wdata_i,
  output logic [PRIV_W-1:0] priv_o,
  output logic [PRIV_W-1:0] mask_o
);
  localparam logic [PRIV_W-1:0] PRIV_RST = '1;
  localparam logic [PRIV_W-1:0] MASK_RST = '0;

  logic sys_trust, ldr_trust;
  logic [PRIV_W-1:0] wperm, keep;
  logic [PRIV_W-1:0] priv_q, mask_q, priv_d, mask_d;
  logic wr_priv, wr_mask, wr_commit;

  assign sys_trust = (ip_region_i == RG_ROM) || (ip_region_i == RG_SYS);
  assign ldr_trust = sys_trust || (ip_region_i == RG_LDR);

  assign wr_priv   = we_i && (sel_i == SEL_PRIV);
  assign wr_mask   = we_i && (sel_i == SEL_MASK);
  assign wr_commit = we_i && (sel_i == SEL_COMMIT);

  // upper pair belongs to the system area, lower pair to the loader area
  for (genvar b = 0; b < PRIV_W; b++) begin : g_bit
    if (b >= PRIV_W / 2) begin : g_sys
      assign wperm[b] = sys_trust;
      assign keep[b]  = sys_trust;
    end else begin : g_ldr
      assign wperm[b] = ldr_trust;
      assign keep[b]  = ldr_trust;
    end

    always_comb begin
      priv_d[b] = priv_q[b];
      mask_d[b] = mask_q[b];
      if (wr_priv) begin
        if (wperm[b]) priv_d[b] = wdata_i[b];
        mask_d[b] = 1'b0;
      end else if (wr_commit) begin
        if (wperm[b]) priv_d[b] = wdata_i[b] & mask_q[b];
        mask_d[b] = 1'b0;
      end else if (wr_mask) begin
        if (wperm[b]) mask_d[b] = wdata_i[b];
      end
      // leaving trusted code wins over any write
      if (!keep[b]) begin
        priv_d[b] = 1'b0;
        mask_d[b] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q <= PRIV_RST;
      mask_q <= MASK_RST;
    end else begin
      priv_q <= priv_d;
      mask_q <= mask_d;
    end
  end

  assign priv_o = priv_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/access_guard.sv
module access_guard
  import mem_priv_pkg::*;
(
  input  logic              valid_i,
  input  logic              write_i,
  input  region_e           region_i,
  input  logic [PRIV_W-1:0] priv_i,
  output logic              block_o
);
  logic allowed;

  always_comb begin
    unique case (region_i)
      RG_SYS:  allowed = write_i ? priv_i[B_SYS_WR] : priv_i[B_SYS_RD];
      RG_LDR:  allowed = write_i ? priv_i[B_LDR_WR] : priv_i[B_LDR_RD];
      default: allowed = 1'b1;
    endcase
  end

  assign block_o = valid_i && !allowed;
endmodule

// File: rtl/mem_priv_ctrl.sv
module mem_priv_ctrl
  import mem_priv_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ROM_LO = 'h0000,
  parameter logic [ADDR_W-1:0] ROM_HI = 'h0FFF,
  parameter logic [ADDR_W-1:0] SYS_LO = 'h1000,
  parameter logic [ADDR_W-1:0] SYS_HI = 'h1FFF,
  parameter logic [ADDR_W-1:0] LDR_LO = 'h2000,
  parameter logic [ADDR_W-1:0] LDR_HI = 'h2FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ip_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  output logic              acc_block_o,
  output logic              fault_o
);
  localparam int unsigned PAD_W = DATA_W - PRIV_W;

  region_e ip_region, acc_region;
  logic [PRIV_W-1:0] priv_q, mask_q;
  logic block;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:PRIV_W];

  code_region_decode #(
    .ADDR_W(ADDR_W), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI), .SYS_LO(SYS_LO),
    .SYS_HI(SYS_HI), .LDR_LO(LDR_LO), .LDR_HI(LDR_HI)
  ) u_ip_dec (
    .addr_i  (ip_i),
    .region_o(ip_region)
  );

  code_region_decode #(
    .ADDR_W(ADDR_W), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI), .SYS_LO(SYS_LO),
    .SYS_HI(SYS_HI), .LDR_LO(LDR_LO), .LDR_HI(LDR_HI)
  ) u_acc_dec (
    .addr_i  (acc_addr_i),
    .region_o(acc_region)
  );

  priv_reg_file u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ip_region_i(ip_region),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i[PRIV_W-1:0]),
    .priv_o     (priv_q),
    .mask_o     (mask_q)
  );

  access_guard u_guard (
    .valid_i (acc_valid_i),
    .write_i (acc_write_i),
    .region_i(acc_region),
    .priv_i  (priv_q),
    .block_o (block)
  );

  always_comb begin
    unique case (reg_sel_i)
      SEL_PRIV: reg_rdata_o = {{PAD_W{1'b0}}, priv_q};
      SEL_MASK: reg_rdata_o = {{PAD_W{1'b0}}, mask_q};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign acc_block_o = block;
  assign fault_o     = block;
endmodule

// File: rtl/mem_priv_ctrl_chk.sv
module mem_priv_ctrl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ROM_LO = 'h0000,
  parameter logic [ADDR_W-1:0] ROM_HI = 'h0FFF,
  parameter logic [ADDR_W-1:0] SYS_LO = 'h1000,
  parameter logic [ADDR_W-1:0] SYS_HI = 'h1FFF,
  parameter logic [ADDR_W-1:0] LDR_LO = 'h2000,
  parameter logic [ADDR_W-1:0] LDR_HI = 'h2FFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] ip_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic [7:0]        reg_rdata_o,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_write_i,
  input logic              acc_block_o,
  input logic              fault_o,
  input logic [3:0]        priv_q,
  input logic [3:0]        mask_q
);
  logic ip_rom, ip_sys, ip_ldr, a_rom, a_sys, a_ldr;
  assign ip_rom = ip_i >= ROM_LO && ip_i <= ROM_HI;
  assign ip_sys = ip_i >= SYS_LO && ip_i <= SYS_HI;
  assign ip_ldr = ip_i >= LDR_LO && ip_i <= LDR_HI;
  assign a_rom  = acc_addr_i >= ROM_LO && acc_addr_i <= ROM_HI;
  assign a_sys  = !a_rom && acc_addr_i >= SYS_LO && acc_addr_i <= SYS_HI;
  assign a_ldr  = !a_rom && !a_sys && acc_addr_i >= LDR_LO && acc_addr_i <= LDR_HI;

  p_hi_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7:4] == 4'b0);

  p_sys_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && a_sys && !(acc_write_i ? priv_q[3] : priv_q[2]) |-> fault_o && acc_block_o);

  p_ldr_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && a_ldr && !(acc_write_i ? priv_q[1] : priv_q[0]) |-> fault_o && acc_block_o);

  p_sys_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ip_rom && !ip_sys |=> priv_q[3:2] == 2'b0 && mask_q[3:2] == 2'b0);

  p_ldr_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ip_rom && !ip_sys && !ip_ldr |=> priv_q[1:0] == 2'b0 && mask_q[1:0] == 2'b0);

  p_no_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> (priv_q & ~$past(priv_q)) == 4'b0);

  p_mask_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_sel_i == 2'd0 |=> mask_q == 4'b0);

  p_commit_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_sel_i == 2'd2 |=> mask_q == 4'b0);

  p_open_area_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_sys && !a_ldr |-> !acc_block_o);

  p_fault_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !fault_o && !acc_block_o);
endmodule

bind mem_priv_ctrl mem_priv_ctrl_chk #(
  .ADDR_W(ADDR_W), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI), .SYS_LO(SYS_LO),
  .SYS_HI(SYS_HI), .LDR_LO(LDR_LO), .LDR_HI(LDR_HI)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ip_i       (ip_i),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .reg_rdata_o(reg_rdata_o),
  .acc_valid_i(acc_valid_i),
  .acc_addr_i (acc_addr_i),
  .acc_write_i(acc_write_i),
  .acc_block_o(acc_block_o),
  .fault_o    (fault_o),
  .priv_q     (priv_q),
  .mask_q     (mask_q)
);

// File: tb/mem_priv_ctrl_tb.sv
module mem_priv_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 0, rst_ni = 0;
  logic [AW-1:0] ip = '0, aa = '0;
  logic we = 0, av = 0, aw = 0;
  logic [1:0] sel = '0;
  logic [7:0] wd = '0, rdata;
  logic blk, flt;

  int checks = 0, fails = 0;
  logic [3:0] m_priv = 4'hF, m_mask = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_priv_ctrl #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ip_i(ip), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .acc_valid_i(av), .acc_addr_i(aa),
    .acc_write_i(aw), .acc_block_o(blk), .fault_o(flt)
  );

  // 0 rom, 1 sys, 2 loader, 3 other
  function automatic int region(input logic [AW-1:0] a);
    if (a <= 16'h0FFF) return 0;
    if (a <= 16'h1FFF) return 1;
    if (a <= 16'h2FFF) return 2;
    return 3;
  endfunction

  function automatic logic [3:0] perm(input int r);
    return {{2{r <= 1}}, {2{r <= 2}}};
  endfunction

  function automatic logic exp_block(input logic v, input logic w,
                                     input logic [AW-1:0] a, input logic [3:0] p);
    int r = region(a);
    if (!v) return 1'b0;
    if (r == 1) return w ? !p[3] : !p[2];
    if (r == 2) return w ? !p[1] : !p[0];
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] s);
    if (s == 2'd0) return {4'h0, m_priv};
    if (s == 2'd1) return {4'h0, m_mask};
    return 8'h00;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic model_update();
    logic [3:0] wp = perm(region(ip));
    if (we) begin
      case (sel)
        2'd0: begin m_priv = (m_priv & ~wp) | (wd[3:0] & wp); m_mask = '0; end
        2'd1: m_mask = (m_mask & ~wp) | (wd[3:0] & wp);
        2'd2: begin m_priv = (m_priv & ~wp) | (wd[3:0] & m_mask & wp); m_mask = '0; end
        default: ;
      endcase
    end
    m_priv &= wp;
    m_mask &= wp;
  endtask

  task automatic step(input logic [AW-1:0] s_ip, input logic s_we, input logic [1:0] s_sel,
                      input logic [7:0] s_wd, input logic s_av, input logic [AW-1:0] s_aa,
                      input logic s_aw, input string req);
    logic eb;
    string areq;
    @(negedge clk);
    ip = s_ip; we = s_we; sel = s_sel; wd = s_wd; av = s_av; aa = s_aa; aw = s_aw;
    #1;
    chk(rdata === exp_rd(s_sel), req, rdata, exp_rd(s_sel));
    eb = exp_block(s_av, s_aw, s_aa, m_priv);
    case (region(s_aa))
      1: areq = "R3";
      2: areq = "R4";
      default: areq = "R11";
    endcase
    if (!s_av) areq = "R12";
    chk(blk === eb, {areq, " block"}, {7'b0, blk}, {7'b0, eb});
    chk(flt === eb, {areq, " fault"}, {7'b0, flt}, {7'b0, eb});
    @(posedge clk);
    model_update();
  endtask

  task automatic rd(input logic [AW-1:0] s_ip, input logic [1:0] s_sel, input string req);
    step(s_ip, 1'b0, s_sel, 8'h00, 1'b0, 16'h0000, 1'b0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #1;
    sel = 2'd0; #1; chk(rdata === 8'h0F, "R1 priv", rdata, 8'h0F);
    sel = 2'd1; #1; chk(rdata === 8'h00, "R1 mask", rdata, 8'h00);
    @(negedge clk); rst_ni = 1;

    // full privilege: protected accesses pass
    step(16'h0100, 0, 2'd0, 0, 1, 16'h1000, 1, "R1");
    step(16'h0100, 0, 2'd3, 0, 1, 16'h2FFF, 0, "R2");
    // drop everything from boot ROM
    step(16'h0100, 1, 2'd0, 8'hF0, 0, 0, 0, "R7");
    rd(16'h0100, 2'd0, "R7");
    step(16'h0100, 0, 2'd0, 0, 1, 16'h1FFF, 0, "R3");
    step(16'h0100, 0, 2'd0, 0, 1, 16'h1000, 1, "R3");
    step(16'h0100, 0, 2'd0, 0, 1, 16'h2000, 1, "R4");
    step(16'h0100, 0, 2'd0, 0, 1, 16'h2FFF, 0, "R4");
    step(16'h0100, 0, 2'd0, 0, 1, 16'h3000, 1, "R11");
    step(16'h0100, 0, 2'd0, 0, 1, 16'h0FFF, 1, "R11");
    step(16'h0100, 0, 2'd0, 0, 0, 16'h1000, 1, "R12");
    // upper bits ignored
    step(16'h1FFF, 1, 2'd0, 8'hFF, 0, 0, 0, "R2");
    rd(16'h1000, 2'd0, "R2");
    // atomic commit from system code
    step(16'h1000, 1, 2'd1, 8'h0A, 0, 0, 0, "R8");
    rd(16'h1000, 2'd1, "R8");
    step(16'h1000, 1, 2'd2, 8'h0F, 0, 0, 0, "R10");
    rd(16'h1000, 2'd0, "R10");
    rd(16'h1000, 2'd1, "R10");
    // privilege write wipes mask
    step(16'h0000, 1, 2'd1, 8'h0F, 0, 0, 0, "R8");
    step(16'h0000, 1, 2'd0, 8'h0F, 0, 0, 0, "R9");
    rd(16'h0000, 2'd1, "R9");
    // loader code: upper pair drops, lower pair writable
    rd(16'h2000, 2'd0, "R5");
    rd(16'h2000, 2'd0, "R5");
    step(16'h2000, 1, 2'd0, 8'h0E, 0, 0, 0, "R7");
    rd(16'h2000, 2'd0, "R7");
    step(16'h2FFF, 1, 2'd1, 8'h0D, 0, 0, 0, "R8");
    rd(16'h2FFF, 2'd1, "R8");
    step(16'h2FFF, 1, 2'd2, 8'h0F, 0, 0, 0, "R10");
    rd(16'h2FFF, 2'd0, "R10");
    // other region: all cleared, writes ignored
    step(16'h3000, 1, 2'd0, 8'h0F, 1, 16'h2000, 0, "R6");
    rd(16'h3000, 2'd0, "R6");
    step(16'h3000, 0, 2'd0, 0, 1, 16'h2000, 0, "R6");

    for (int i = 0; i < 3000; i++) begin
      int rr = $urandom_range(0, 9);
      int ar = $urandom_range(0, 3);
      logic [AW-1:0] rip, raddr;
      rip = (rr < 4) ? AW'($urandom_range(16'h0000, 16'h0FFF)) :
            (rr < 7) ? AW'($urandom_range(16'h1000, 16'h1FFF)) :
            (rr < 9) ? AW'($urandom_range(16'h2000, 16'h2FFF)) :
                       AW'($urandom_range(16'h3000, 16'hFFFF));
      raddr = (ar == 0) ? AW'($urandom_range(16'h0000, 16'h0FFF)) :
              (ar == 1) ? AW'($urandom_range(16'h1000, 16'h1FFF)) :
              (ar == 2) ? AW'($urandom_range(16'h2000, 16'h2FFF)) :
                          AW'($urandom_range(16'h3000, 16'hFFFF));
      step(rip, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 8'($urandom),
           1'($urandom_range(0, 1)), raddr, 1'($urandom_range(0, 1)), "R2 R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule